// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block collects interrupt requests from a fixed number of peripheral sources and tells the CPU which one to service next. Each source has a one-bit pending latch that a peripheral sets with a single-cycle request pulse. Each source also has a three-bit priority level. The controller also holds a global enable bit and a three-bit threshold. On every clock it searches the sources for an acceptable request and registers the winner's index and level. It drives a pending output towards the CPU while a winner exists.

The CPU takes the interrupt by raising `cpu_ack` for one cycle while `irq_valid` is high. The latch of the reported source is then cleared. Software programs levels, the enable bit and the threshold through simple write strobes. Software may also clear, but never set, a pending latch.

The registered outputs are computed from the state the registers hold after the same clock edge. An acknowledged source therefore never shows up again in the cycle after its acknowledge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all pending latches, all level fields, the enable bit and the threshold read 0, and `irq_valid`, `irq_id` and `irq_lvl` are 0.
- R2: A request pulse on `req_pulse[i]` sets pending latch i to 1 at the next clock edge.
- R3: `cpu_ack` high while `irq_valid` is high clears the latch of the source shown on `irq_id` at that edge. `cpu_ack` while `irq_valid` is low changes nothing.
- R4: A software write with `pend_wdata` = 0 clears the addressed latch. A write with `pend_wdata` = 1 leaves the latch unchanged.
- R5: Level code 3'b000 disables a source completely. Codes 3'b001 to 3'b111 mean levels 1 (lowest) to 7 (highest).
- R6: A source is acceptable only when the enable bit is 1, its latch is 1, and its level is strictly greater than the threshold. A threshold of 3'b111 therefore blocks every source.
- R7: The enable bit, the pending latches, the level fields and the threshold are separate storage. A write to one leaves the others unchanged.
- R8: Among acceptable sources that share the highest level, the lowest index wins.
- R9: The acceptable source with the highest level wins, whatever its index.
- R10: `irq_valid`, `irq_id`, `irq_lvl`, `pend_vec`, `ien_o` and `thr_o` are registered. They show the state as it stands after the edge that updated it, so a source that was just acknowledged or cleared is no longer reported.
- R11: A request pulse in the same cycle as a clear of that latch, whether by acknowledge or by software, wins. The latch stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_pulse | input | NUM_SRC | One-cycle request pulses from the peripherals |
| cpu_ack | input | 1 | CPU takes the interrupt shown on irq_id |
| lvl_we | input | 1 | Write strobe for a source level |
| lvl_idx | input | ID_W | Source addressed by the level write |
| lvl_wdata | input | 3 | New level code |
| pend_we | input | 1 | Write strobe for a pending latch |
| pend_idx | input | ID_W | Source addressed by the pending write |
| pend_wdata | input | 1 | 0 clears the latch, 1 has no effect |
| ien_we | input | 1 | Write strobe for the global enable bit |
| ien_wdata | input | 1 | New enable value |
| thr_we | input | 1 | Write strobe for the threshold |
| thr_wdata | input | 3 | New threshold |
| rd_idx | input | ID_W | Source whose level appears on rd_lvl |
| rd_lvl | output | 3 | Level of source rd_idx |
| pend_vec | output | NUM_SRC | Current pending latches |
| ien_o | output | 1 | Current enable bit |
| thr_o | output | 3 | Current threshold |
| irq_valid | output | 1 | An acceptable source exists |
| irq_id | output | ID_W | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- **Ties at the top level.** A design that resolves ties towards the higher index would report source 5 instead of source 3.
- **Threshold equal to the level.** A design using `>=` would accept the source.
- **Threshold of 7.** This must block even a level-7 source.
- **Acknowledge followed by the next winner.** A design that arbitrates on stale latches would present the just-acknowledged source again.
- **Level 0, software write of 1, and acknowledge with nothing pending.** These must leave the observable state untouched. A design that lets a write of 1 set a latch would raise `irq_valid`.
- **Request pulse on a latch being cleared.** The pulse arrives in the same cycle as an acknowledge or software clear of that latch. A design that gives priority to the clear would lose the request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] prio_t;
  localparam prio_t PRIO_OFF = '0;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_i,
  input  logic  ack_clr_i,
  input  logic  sw_clr_i,
  input  logic  lvl_we_i,
  input  prio_t lvl_wdata_i,
  input  logic  ien_d_i,
  input  prio_t thr_d_i,
  output logic  pend_q_o,
  output logic  pend_d_o,
  output prio_t lvl_q_o,
  output prio_t lvl_d_o,
  output logic  elig_d_o
);
  logic  pend_q, pend_d;
  prio_t lvl_q, lvl_d;

  // next state: a fresh request beats any clear in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (ack_clr_i || sw_clr_i) pend_d = 1'b0;
    if (req_i)                 pend_d = 1'b1;
    lvl_d = lvl_q;
    if (lvl_we_i)              lvl_d = lvl_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lvl_q  <= PRIO_OFF;
    end else begin
      pend_q <= pend_d;
      if (lvl_we_i) lvl_q <= lvl_d;
    end
  end

  assign elig_d_o = ien_d_i && pend_d && (lvl_d > thr_d_i);
  assign pend_q_o = pend_q;
  assign pend_d_o = pend_d;
  assign lvl_q_o  = lvl_q;
  assign lvl_d_o  = lvl_d;

  // R2 / R11: a request always lands in the latch
  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> pend_q);
  // R3: acknowledge without a new request empties the latch
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr_i && !req_i) |=> !pend_q);
  // R4: a latch can only rise through a request
  p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !req_i) |=> !pend_q);
  // R7: level storage moves only on its own strobe
  p_lvl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_we_i |=> $stable(lvl_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] elig_i,
  input  prio_t              lvl_i [NUM_SRC],
  output logic               found_o,
  output logic [ID_W-1:0]    id_o,
  output prio_t              lvl_o
);
  // linear scan: strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    lvl_o   = PRIO_OFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!found_o || (lvl_i[i] > lvl_o))) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_pulse,
  input  logic               cpu_ack,
  input  logic               lvl_we,
  input  logic [ID_W-1:0]    lvl_idx,
  input  logic [2:0]         lvl_wdata,
  input  logic               pend_we,
  input  logic [ID_W-1:0]    pend_idx,
  input  logic               pend_wdata,
  input  logic               ien_we,
  input  logic               ien_wdata,
  input  logic               thr_we,
  input  logic [2:0]         thr_wdata,
  input  logic [ID_W-1:0]    rd_idx,
  output logic [2:0]         rd_lvl,
  output logic [NUM_SRC-1:0] pend_vec,
  output logic               ien_o,
  output logic [2:0]         thr_o,
  output logic               irq_valid,
  output logic [ID_W-1:0]    irq_id,
  output logic [2:0]         irq_lvl
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // global state
  logic  ien_q, ien_d;
  prio_t thr_q, thr_d;
  logic            valid_q;
  logic [ID_W-1:0] id_q;
  prio_t           wlvl_q;

  always_comb begin
    ien_d = ien_we ? ien_wdata : ien_q;
    thr_d = thr_we ? thr_wdata : thr_q;
  end

  logic               ack_take;
  logic [NUM_SRC-1:0] pend_q_v, pend_d_v, elig_v;
  prio_t              lvl_q_a [NUM_SRC];
  prio_t              lvl_d_a [NUM_SRC];

  assign ack_take = cpu_ack && valid_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic ack_hit, sw_hit, lvl_hit;
    assign ack_hit = ack_take && (id_q == ID_W'(g));
    assign sw_hit  = pend_we && !pend_wdata && (pend_idx == ID_W'(g));
    assign lvl_hit = lvl_we && (lvl_idx == ID_W'(g));
    irq_src_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_i_n),
      .req_i       (req_pulse[g]),
      .ack_clr_i   (ack_hit),
      .sw_clr_i    (sw_hit),
      .lvl_we_i    (lvl_hit),
      .lvl_wdata_i (lvl_wdata),
      .ien_d_i     (ien_d),
      .thr_d_i     (thr_d),
      .pend_q_o    (pend_q_v[g]),
      .pend_d_o    (pend_d_v[g]),
      .lvl_q_o     (lvl_q_a[g]),
      .lvl_d_o     (lvl_d_a[g]),
      .elig_d_o    (elig_v[g])
    );
  end

  // arbitration on next-state values so outputs match the registers
  logic            win_found;
  logic [ID_W-1:0] win_id;
  prio_t           win_lvl;

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .elig_i  (elig_v),
    .lvl_i   (lvl_d_a),
    .found_o (win_found),
    .id_o    (win_id),
    .lvl_o   (win_lvl)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ien_q   <= 1'b0;
      thr_q   <= PRIO_OFF;
      valid_q <= 1'b0;
      id_q    <= '0;
      wlvl_q  <= PRIO_OFF;
    end else begin
      if (ien_we) ien_q <= ien_d;
      if (thr_we) thr_q <= thr_d;
      valid_q <= win_found;
      id_q    <= win_id;
      wlvl_q  <= win_lvl;
    end
  end

  assign rd_lvl    = lvl_q_a[rd_idx];
  assign pend_vec  = pend_q_v;
  assign ien_o     = ien_q;
  assign thr_o     = thr_q;
  assign irq_valid = valid_q;
  assign irq_id    = id_q;
  assign irq_lvl   = wlvl_q;

  // R6: nothing is offered while the enable bit is off
  p_ien_gate_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ien_q |-> !valid_q);
  // R6: an offered level is strictly above the threshold
  p_above_thr_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    valid_q |-> (wlvl_q > thr_q));
  // R5: level 0 is never offered
  p_lvl_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    valid_q |-> (wlvl_q != PRIO_OFF));
  // R10: the offered source has its latch set
  p_win_pending_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    valid_q |-> pend_q_v[id_q]);
  // R7: threshold and enable move only on their own strobes
  p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!thr_we && !ien_we) |=> ($stable(thr_q) && $stable(ien_q)));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req_pulse;
  logic cpu_ack, lvl_we, pend_we, pend_wdata, ien_we, ien_wdata, thr_we;
  logic [IW-1:0] lvl_idx, pend_idx, rd_idx;
  logic [2:0] lvl_wdata, thr_wdata;
  logic [2:0] rd_lvl, thr_o, irq_lvl;
  logic [N-1:0] pend_vec;
  logic ien_o, irq_valid;
  logic [IW-1:0] irq_id;

  always #(PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .cpu_ack(cpu_ack),
    .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_wdata(lvl_wdata),
    .pend_we(pend_we), .pend_idx(pend_idx), .pend_wdata(pend_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .rd_idx(rd_idx), .rd_lvl(rd_lvl), .pend_vec(pend_vec), .ien_o(ien_o),
    .thr_o(thr_o), .irq_valid(irq_valid), .irq_id(irq_id), .irq_lvl(irq_lvl)
  );

  typedef struct {
    string         tag;
    logic          valid;
    logic [IW-1:0] id;
    logic [2:0]    lvl;
    logic [N-1:0]  pend;
    logic          ien;
    logic [2:0]    thr;
    logic [2:0]    rdl;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model
  logic [N-1:0]  m_pend;
  logic [2:0]    m_lvl [N];
  logic          m_ien;
  logic [2:0]    m_thr;
  logic          m_valid;
  logic [IW-1:0] m_id;
  logic [2:0]    m_wl;

  task automatic idle();
    req_pulse = '0; cpu_ack = 0; lvl_we = 0; pend_we = 0; ien_we = 0; thr_we = 0;
    lvl_idx = '0; lvl_wdata = '0; pend_idx = '0; pend_wdata = 0;
    ien_wdata = 0; thr_wdata = '0;
  endtask

  // driver: inputs are set by the caller, one clock is applied,
  // the model is advanced and the expected item is queued
  task automatic step(input string tag);
    logic ack_take;
    @(posedge clk);
    #1;
    ack_take = cpu_ack && m_valid;
    for (int i = 0; i < N; i++) begin
      if (ack_take && m_id == IW'(i)) m_pend[i] = 1'b0;
      if (pend_we && !pend_wdata && pend_idx == IW'(i)) m_pend[i] = 1'b0;
      if (req_pulse[i]) m_pend[i] = 1'b1;
      if (lvl_we && lvl_idx == IW'(i)) m_lvl[i] = lvl_wdata;
    end
    if (ien_we) m_ien = ien_wdata;
    if (thr_we) m_thr = thr_wdata;
    m_valid = 0; m_id = '0; m_wl = '0;
    for (int i = 0; i < N; i++) begin
      if (m_ien && m_pend[i] && m_lvl[i] > m_thr && (!m_valid || m_lvl[i] > m_wl)) begin
        m_valid = 1; m_id = IW'(i); m_wl = m_lvl[i];
      end
    end
    exp_q.push_back('{tag, m_valid, m_id, m_wl, m_pend, m_ien, m_thr, m_lvl[rd_idx]});
    idle();
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (irq_valid !== e.valid || irq_id !== e.id || irq_lvl !== e.lvl ||
          pend_vec !== e.pend || ien_o !== e.ien || thr_o !== e.thr || rd_lvl !== e.rdl) begin
        n_bad++;
        $display("FAIL %s: act v=%0b id=%0d lvl=%0d pend=%b ien=%0b thr=%0d rd=%0d exp v=%0b id=%0d lvl=%0d pend=%b ien=%0b thr=%0d rd=%0d",
          e.tag, irq_valid, irq_id, irq_lvl, pend_vec, ien_o, thr_o, rd_lvl,
          e.valid, e.id, e.lvl, e.pend, e.ien, e.thr, e.rdl);
      end
    end
  end

  initial begin
    #(PERIOD*100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rd_idx = 3'd6;
    m_pend = '0; m_ien = 0; m_thr = '0; m_valid = 0; m_id = '0; m_wl = '0;
    for (int i = 0; i < N; i++) m_lvl[i] = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    n_vec++;
    if (irq_valid !== 0 || irq_id !== 0 || irq_lvl !== 0 || pend_vec !== 0 ||
        ien_o !== 0 || thr_o !== 0 || rd_lvl !== 0) begin
      n_bad++;
      $display("FAIL R1: act v=%0b pend=%b ien=%0b thr=%0d exp all zero",
               irq_valid, pend_vec, ien_o, thr_o);
    end
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    step("R1 idle after release");

    lvl_we = 1; lvl_idx = 3; lvl_wdata = 5;     step("R7 level write only");
    lvl_we = 1; lvl_idx = 5; lvl_wdata = 5;     step("R7 level write only");
    lvl_we = 1; lvl_idx = 1; lvl_wdata = 2;     step("R7 level write only");
    lvl_we = 1; lvl_idx = 6; lvl_wdata = 4;     step("R7 level write rd_idx");
    req_pulse = 8'b0000_0010;                   step("R6 enable off blocks");
    ien_we = 1; ien_wdata = 1;                  step("R10 enable takes effect same edge");
    req_pulse = 8'b0010_1000;                   step("R8 tie lowest index");
    step("R9 hold highest");
    cpu_ack = 1;                                step("R3 ack moves to next");
    cpu_ack = 1;                                step("R9 then lower level");
    cpu_ack = 1;                                step("R3 last ack empties");
    cpu_ack = 1;                                step("R3 ack while idle ignored");
    req_pulse = 8'b0000_0001;                   step("R5 level 0 disabled");
    pend_we = 1; pend_idx = 0; pend_wdata = 0;  step("R4 software clear");
    pend_we = 1; pend_idx = 2; pend_wdata = 1;  step("R4 write 1 ignored");
    thr_we = 1; thr_wdata = 4;                  step("R7 threshold write only");
    req_pulse = 8'b0100_0000;                   step("R6 level equal threshold blocked");
    thr_we = 1; thr_wdata = 3;                  step("R6 level above threshold");
    lvl_we = 1; lvl_idx = 7; lvl_wdata = 7;     step("R9 level write");
    req_pulse = 8'b1000_0000;                   step("R9 level 7 wins");
    thr_we = 1; thr_wdata = 7;                  step("R6 threshold 7 blocks all");
    thr_we = 1; thr_wdata = 0;                  step("R6 threshold 0");
    cpu_ack = 1; req_pulse = 8'b1000_0000;      step("R11 pulse beats ack");
    pend_we = 1; pend_idx = 7; pend_wdata = 0;
    req_pulse = 8'b1000_0000;                   step("R11 pulse beats sw clear");
    pend_we = 1; pend_idx = 7; pend_wdata = 0;  step("R4 clear winner");
    ien_we = 1; ien_wdata = 0;                  step("R6 enable off hides pending");
    ien_we = 1; ien_wdata = 1;                  step("R7 latches kept");
    lvl_we = 1; lvl_idx = 6; lvl_wdata = 0;     step("R5 level 0 removes source");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule